// File: doc/BRIEF.md
# Interrupt Source Crossbar Router

This block connects a wide set of peripheral interrupt request lines to a much smaller set of interrupt controller input lines. Every output line that can be routed owns a select register. The register holds the number of the source line that drives that output. A write port programs the registers, and a read port returns what they hold, so the routing can be inspected. Every request line is level-sensitive and active-high.

Output lines come in three kinds, fixed at build time:

- **Reserved lines** have no select register and no address. They always follow a matching direct input line.
- **Bypass lines** have a select register that can be written and read. Their output still follows a fixed direct input line.
- **Normal routable lines** are driven by whichever source their register names.

Registers are packed into the address space in increasing output order, and reserved lines are skipped. A release command returns a routable output to a build-time safe source number. That safe number is also the reset value of every routable register. Deciding which output to allocate to a given source is left to a separate block.

Top module: `xbar_router`

## Requirements
- R1: While reset is active and after it is released, every routable select register holds SAFE_SRC and every bypass select register holds zero, until written.
- R2: The register of output k sits at byte address REG_BYTES × (number of non-reserved outputs below k). An unaligned address, or an address at or past REG_BYTES × NUM_REGS, is ignored by writes and reads as zero.
- R3: A routable output k drives src_irq_i[sel_k], where sel_k is the stored select value. A write lands at the clock edge that samples wr_en_i, and the output follows the new source from that edge on.
- R4: A routable output whose stored select value is NUM_SRC or more is driven low, whatever the source lines do.
- R5: A reserved output k always drives direct_irq_i[k] and owns no address.
- R6: A bypass output k always drives direct_irq_i[k]. Writes to its register are still stored and can be read back, but they have no effect on the output.
- R7: rel_en_i loads SAFE_SRC into the routable register at addr_i. On a bypass register it changes nothing. It takes priority over a write issued in the same cycle.
- R8: rd_data_o returns, combinationally, the stored value of the register at rd_addr_i.
- R9: Each select register keeps all 8 × REG_BYTES bits written to it, including bits above the range of valid source numbers.
- R10: With neither wr_en_i nor rel_en_i asserted, no select register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_irq_i | input | NUM_SRC | Routable peripheral interrupt requests |
| direct_irq_i | input | NUM_OUT | Hardwired requests for reserved and bypass outputs |
| wr_en_i | input | 1 | Write the select register at addr_i |
| rel_en_i | input | 1 | Release the routable register at addr_i back to SAFE_SRC |
| addr_i | input | AW | Byte address for writes and releases |
| wr_data_i | input | 8·REG_BYTES | Write data (select value) |
| rd_addr_i | input | AW | Byte address for reads |
| rd_data_o | output | 8·REG_BYTES | Stored select value, zero for an invalid address |
| irq_o | output | NUM_OUT | Requests toward the interrupt controller |

## Verification
The bench builds the block with 20 sources, 12 outputs, 2-byte registers, outputs 0, 3 and 7 reserved, outputs 5 and 9 bypass, and a safe source of 2. With these values every register address, including the end of the space and the unaligned holes, can be swept. Every legal source number, plus the first out-of-range values, can be written to one output. Because the source count is not a power of two, the out-of-range test is a real comparison rather than a bit-width effect. Because the safe source is nonzero, the reset value of a routable register can be told apart from that of a bypass register.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  localparam int XBAR_MAX_OUT = 1024;

  // Position of output k in the packed register space: count of
  // non-reserved outputs strictly below k.
  function automatic int xbar_reg_index(input logic [XBAR_MAX_OUT-1:0] rsvd,
                                        input int k);
    int n;
    n = 0;
    for (int j = 0; j < k; j++) begin
      if (!rsvd[j]) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/xbar_rst_sync.sv
module xbar_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/xbar_regfile.sv
module xbar_regfile
  import xbar_pkg::*;
#(
  parameter int                 NUM_OUT   = 160,
  parameter int                 REG_BYTES = 2,
  parameter logic [NUM_OUT-1:0] RSVD_MASK = '0,
  parameter logic [NUM_OUT-1:0] BYP_MASK  = '0,
  parameter int                 SAFE_SRC  = 0,
  parameter int                 AW        = 9
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         rel_en,
  input  logic [AW-1:0]                addr,
  input  logic [8*REG_BYTES-1:0]       wr_data,
  input  logic [AW-1:0]                rd_addr,
  output logic [8*REG_BYTES-1:0]       rd_data,
  output logic [NUM_OUT*8*REG_BYTES-1:0] sel_flat
);

  localparam int REG_W    = 8 * REG_BYTES;
  localparam int NUM_REGS = NUM_OUT - $countones(RSVD_MASK);
  localparam int IW       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [REG_W-1:0] by_idx [NUM_REGS];

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    if (RSVD_MASK[k]) begin : g_rsvd
      assign sel_flat[k*REG_W +: REG_W] = '0;
    end else begin : g_reg
      localparam int            IDX     = xbar_reg_index(XBAR_MAX_OUT'(RSVD_MASK), k);
      localparam logic [AW-1:0] ADDR    = AW'(IDX * REG_BYTES);
      localparam bit            IS_BYP  = BYP_MASK[k];
      localparam logic [REG_W-1:0] RST_VAL = IS_BYP ? '0 : REG_W'(SAFE_SRC);

      logic             hit;
      logic             en;
      logic [REG_W-1:0] sel_d;
      logic [REG_W-1:0] sel_q;

      assign hit = (addr == ADDR);

      always_comb begin
        en    = 1'b0;
        sel_d = sel_q;
        if (rel_en && hit) begin
          if (!IS_BYP) begin
            en    = 1'b1;
            sel_d = REG_W'(SAFE_SRC);
          end
        end else if (wr_en && hit) begin
          en    = 1'b1;
          sel_d = wr_data;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  sel_q <= RST_VAL;
        else if (en) sel_q <= sel_d;
      end

      assign by_idx[IDX]                = sel_q;
      assign sel_flat[k*REG_W +: REG_W] = sel_q;
    end
  end

  logic [31:0]   rd_full;
  logic          rd_ok;
  logic [IW-1:0] rd_idx;

  assign rd_full = 32'(rd_addr);
  assign rd_ok   = ((rd_full % 32'(REG_BYTES)) == 32'd0) &&
                   ((rd_full / 32'(REG_BYTES)) < 32'(NUM_REGS));
  assign rd_idx  = IW'(rd_full / 32'(REG_BYTES));
  assign rd_data = rd_ok ? by_idx[rd_idx] : '0;

endmodule

// File: rtl/xbar_route.sv
module xbar_route #(
  parameter int                 NUM_SRC   = 400,
  parameter int                 NUM_OUT   = 160,
  parameter int                 REG_BYTES = 2,
  parameter logic [NUM_OUT-1:0] RSVD_MASK = '0,
  parameter logic [NUM_OUT-1:0] BYP_MASK  = '0
) (
  input  logic [NUM_SRC-1:0]             src_irq,
  input  logic [NUM_OUT-1:0]             direct_irq,
  input  logic [NUM_OUT*8*REG_BYTES-1:0] sel_flat,
  output logic [NUM_OUT-1:0]             irq
);

  localparam int REG_W = 8 * REG_BYTES;
  localparam int SW    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    if (RSVD_MASK[k] || BYP_MASK[k]) begin : g_fixed
      logic unused_sel;
      assign unused_sel = ^sel_flat[k*REG_W +: REG_W];
      assign irq[k]     = direct_irq[k];
    end else begin : g_mux
      logic [REG_W-1:0] sel;
      logic [32:0]      sel_ext;
      logic             in_range;
      logic [SW-1:0]    idx;

      assign sel      = sel_flat[k*REG_W +: REG_W];
      assign sel_ext  = 33'(sel);
      assign in_range = (sel_ext < 33'(NUM_SRC));
      assign idx      = SW'(sel);
      assign irq[k]   = in_range ? src_irq[idx] : 1'b0;
    end
  end

endmodule

// File: rtl/xbar_router.sv
module xbar_router
  import xbar_pkg::*;
#(
  parameter int NUM_SRC   = 400,
  parameter int NUM_OUT   = 160,
  parameter int REG_BYTES = 2,
  parameter logic [NUM_OUT-1:0] RSVD_MASK = (160'h18 << 128) | 160'h6F,
  parameter logic [NUM_OUT-1:0] BYP_MASK  = (160'h1820 << 128) | 160'h400,
  parameter int SAFE_SRC  = 0,
  localparam int REG_W    = 8 * REG_BYTES,
  localparam int NUM_REGS = NUM_OUT - $countones(RSVD_MASK),
  localparam int AW       = (NUM_REGS * REG_BYTES > 2) ? $clog2(NUM_REGS * REG_BYTES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_irq_i,
  input  logic [NUM_OUT-1:0] direct_irq_i,
  input  logic               wr_en_i,
  input  logic               rel_en_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [REG_W-1:0]   wr_data_i,
  input  logic [AW-1:0]      rd_addr_i,
  output logic [REG_W-1:0]   rd_data_o,
  output logic [NUM_OUT-1:0] irq_o
);

  logic                     rst_sync_n;
  logic [NUM_OUT*REG_W-1:0] sel_flat;

  xbar_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  xbar_regfile #(
    .NUM_OUT   (NUM_OUT),
    .REG_BYTES (REG_BYTES),
    .RSVD_MASK (RSVD_MASK),
    .BYP_MASK  (BYP_MASK),
    .SAFE_SRC  (SAFE_SRC),
    .AW        (AW)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en_i),
    .rel_en   (rel_en_i),
    .addr     (addr_i),
    .wr_data  (wr_data_i),
    .rd_addr  (rd_addr_i),
    .rd_data  (rd_data_o),
    .sel_flat (sel_flat)
  );

  xbar_route #(
    .NUM_SRC   (NUM_SRC),
    .NUM_OUT   (NUM_OUT),
    .REG_BYTES (REG_BYTES),
    .RSVD_MASK (RSVD_MASK),
    .BYP_MASK  (BYP_MASK)
  ) u_route (
    .src_irq    (src_irq_i),
    .direct_irq (direct_irq_i),
    .sel_flat   (sel_flat),
    .irq        (irq_o)
  );

endmodule

// File: rtl/xbar_router_chk.sv
module xbar_router_chk
  import xbar_pkg::*;
#(
  parameter int                 NUM_SRC   = 400,
  parameter int                 NUM_OUT   = 160,
  parameter int                 REG_BYTES = 2,
  parameter logic [NUM_OUT-1:0] RSVD_MASK = '0,
  parameter logic [NUM_OUT-1:0] BYP_MASK  = '0,
  parameter int                 SAFE_SRC  = 0,
  parameter int                 AW        = 9
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             wr_en,
  input logic                             rel_en,
  input logic [AW-1:0]                    addr,
  input logic [8*REG_BYTES-1:0]           wr_data,
  input logic [NUM_SRC-1:0]               src_irq,
  input logic [NUM_OUT-1:0]               direct_irq,
  input logic [NUM_OUT-1:0]               irq,
  input logic [NUM_OUT*8*REG_BYTES-1:0]   sel_flat
);

  localparam int REG_W = 8 * REG_BYTES;

  // R10: no command, no register change
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rel_en) |=> $stable(sel_flat));

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_k
    if (!RSVD_MASK[k]) begin : g_reg
      localparam int            IDX  = xbar_reg_index(XBAR_MAX_OUT'(RSVD_MASK), k);
      localparam logic [AW-1:0] ADDR = AW'(IDX * REG_BYTES);

      logic [REG_W-1:0] sel_k;
      assign sel_k = sel_flat[k*REG_W +: REG_W];

      // R3 / R9: plain write stores the full word
      a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rel_en && addr == ADDR) |=> (sel_k == $past(wr_data)));

      if (BYP_MASK[k]) begin : g_byp
        // R7: release leaves a bypass register alone
        a_r7_bypass_release_kept: assert property (@(posedge clk) disable iff (!rst_n)
          (rel_en && addr == ADDR) |=> $stable(sel_k));
        // R6: bypass output ignores a register change
        a_r6_bypass_direct: assert property (@(posedge clk) disable iff (!rst_n)
          !$stable(sel_k) |-> (irq[k] == direct_irq[k]));
      end else begin : g_norm
        // R7: release of routable register yields safe source
        a_r7_release_safe: assert property (@(posedge clk) disable iff (!rst_n)
          (rel_en && addr == ADDR) |=> (sel_k == REG_W'(SAFE_SRC)));
        // R4: out-of-range select keeps output low
        a_r4_range_low: assert property (@(posedge clk) disable iff (!rst_n)
          (33'(sel_k) >= 33'(NUM_SRC)) |-> !irq[k]);
        // R3: in-range select follows its source
        a_r3_follows_src: assert property (@(posedge clk) disable iff (!rst_n)
          (33'(sel_k) < 33'(NUM_SRC)) |-> (irq[k] == src_irq[sel_k]));
      end
    end
  end

endmodule

bind xbar_router xbar_router_chk #(
  .NUM_SRC   (NUM_SRC),
  .NUM_OUT   (NUM_OUT),
  .REG_BYTES (REG_BYTES),
  .RSVD_MASK (RSVD_MASK),
  .BYP_MASK  (BYP_MASK),
  .SAFE_SRC  (SAFE_SRC),
  .AW        (AW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .wr_en      (wr_en_i),
  .rel_en     (rel_en_i),
  .addr       (addr_i),
  .wr_data    (wr_data_i),
  .src_irq    (src_irq_i),
  .direct_irq (direct_irq_i),
  .irq        (irq_o),
  .sel_flat   (sel_flat)
);

// File: tb/sim_xbar_router.sv
`timescale 1ns/1ps
module sim_xbar_router;

  localparam int NS   = 20;
  localparam int NO   = 12;
  localparam int SAFE = 2;

  logic          clk;
  logic          rst_n;
  logic [NS-1:0] src;
  logic [NO-1:0] dir;
  logic          wr_en;
  logic          rel_en;
  logic [4:0]    addr;
  logic [15:0]   wdata;
  logic [4:0]    raddr;
  logic [15:0]   rdata;
  logic [NO-1:0] irq;

  int tests;
  int fails;
  bit cyc_on;
  bit rnd_on;
  bit done;
  int msel [NO];

  xbar_router #(
    .NUM_SRC   (NS),
    .NUM_OUT   (NO),
    .REG_BYTES (2),
    .RSVD_MASK (12'h089),
    .BYP_MASK  (12'h220),
    .SAFE_SRC  (SAFE)
  ) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_irq_i    (src),
    .direct_irq_i (dir),
    .wr_en_i      (wr_en),
    .rel_en_i     (rel_en),
    .addr_i       (addr),
    .wr_data_i    (wdata),
    .rd_addr_i    (raddr),
    .rd_data_o    (rdata),
    .irq_o        (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic bit is_rsvd(int k);
    return (k == 0) || (k == 3) || (k == 7);
  endfunction

  function automatic bit is_byp(int k);
    return (k == 5) || (k == 9);
  endfunction

  function automatic int addr_of(int k);
    int n = 0;
    for (int j = 0; j < k; j++) if (!is_rsvd(j)) n++;
    return 2 * n;
  endfunction

  function automatic int model_read(int a);
    for (int k = 0; k < NO; k++)
      if (!is_rsvd(k) && addr_of(k) == a) return msel[k];
    return 0;
  endfunction

  function automatic bit exp_irq(int k);
    if (is_rsvd(k) || is_byp(k)) return dir[k];
    if (msel[k] < NS) return src[msel[k]];
    return 1'b0;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference model of the register state
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NO; k++) msel[k] = is_byp(k) ? 0 : SAFE;
    end else if (wr_en || rel_en) begin
      for (int k = 0; k < NO; k++) begin
        if (!is_rsvd(k) && addr_of(k) == int'(addr)) begin
          if (rel_en) begin
            if (!is_byp(k)) msel[k] = SAFE;
          end else begin
            msel[k] = int'(wdata);
          end
        end
      end
    end
  end

  // random source activity
  always @(posedge clk) begin
    #2;
    if (rnd_on) begin
      src = NS'({$urandom, $urandom});
      dir = NO'($urandom);
    end
  end

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #5;
    if (cyc_on) begin
      bit bad = 1'b0;
      for (int k = 0; k < NO; k++) begin
        if (irq[k] !== exp_irq(k)) begin
          bad = 1'b1;
          if (is_rsvd(k))      $display("FAIL R5: out %0d actual %0b expected %0b", k, irq[k], exp_irq(k));
          else if (is_byp(k))  $display("FAIL R6: out %0d actual %0b expected %0b", k, irq[k], exp_irq(k));
          else if (msel[k] >= NS) $display("FAIL R4: out %0d actual %0b expected %0b", k, irq[k], exp_irq(k));
          else                 $display("FAIL R3: out %0d actual %0b expected %0b", k, irq[k], exp_irq(k));
        end
      end
      tests++;
      if (bad) fails++;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    addr = 5'(a); wdata = 16'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rel(int a, bit with_wr, int d);
    @(negedge clk);
    addr = 5'(a); wdata = 16'(d); rel_en = 1'b1; wr_en = with_wr;
    @(negedge clk);
    rel_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rd_chk(int a, int exp, string tag);
    @(negedge clk);
    raddr = 5'(a);
    #1;
    chk(rdata === 16'(exp), tag, int'(rdata), exp);
  endtask

  initial begin
    tests = 0; fails = 0; cyc_on = 0; rnd_on = 0; done = 0;
    rst_n = 0; src = '0; dir = '0; wr_en = 0; rel_en = 0;
    addr = '0; wdata = '0; raddr = '0;
    repeat (3) @(posedge clk);
    #1;
    rd_chk(0, SAFE, "R1 in reset");
    rst_n = 1;
    repeat (4) @(posedge clk);
    cyc_on = 1; rnd_on = 1;

    // R1 / R8: reset contents across every valid address
    for (int k = 0; k < NO; k++)
      if (!is_rsvd(k)) rd_chk(addr_of(k), is_byp(k) ? 0 : SAFE, "R1 reset value");
    // R2: end of space and unaligned holes read zero
    rd_chk(18, 0, "R2 past end read");
    rd_chk(3, 0, "R2 unaligned read");

    // R3 / R8: program every routable output
    for (int k = 0; k < NO; k++)
      if (!is_rsvd(k) && !is_byp(k)) wr(addr_of(k), k + 3);
    for (int k = 0; k < NO; k++)
      if (!is_rsvd(k) && !is_byp(k)) rd_chk(addr_of(k), k + 3, "R3 programmed select");

    // R6: bypass writes stored, output stays direct
    wr(addr_of(5), 4);
    wr(addr_of(9), 11);
    rd_chk(addr_of(5), 4, "R6 bypass stored");
    rd_chk(addr_of(9), 11, "R6 bypass stored");
    rnd_on = 0;
    @(negedge clk); src = '1; dir = '0; #1;
    chk(irq[5] === 1'b0, "R6 bypass follows direct", irq[5], 0);
    @(negedge clk); src = '0; dir[5] = 1'b1; #1;
    chk(irq[5] === 1'b1, "R6 bypass follows direct", irq[5], 1);
    chk(irq[0] === 1'b0, "R5 reserved follows direct", irq[0], 0);
    @(negedge clk); dir[0] = 1'b1; #1;
    chk(irq[0] === 1'b1, "R5 reserved follows direct", irq[0], 1);

    // R3: routing switch lands at the write edge
    wr(addr_of(1), 4);
    @(negedge clk); src = '0; src[6] = 1'b1;
    addr = 5'(addr_of(1)); wdata = 16'd6; wr_en = 1'b1; #1;
    chk(irq[1] === 1'b0, "R3 old route before edge", irq[1], 0);
    @(posedge clk); #1;
    chk(irq[1] === 1'b1, "R3 new route after edge", irq[1], 1);
    @(negedge clk); wr_en = 1'b0;

    // R3 boundary: last legal source
    wr(addr_of(1), NS - 1);
    @(negedge clk); src = '0; src[NS-1] = 1'b1; #1;
    chk(irq[1] === 1'b1, "R3 last source", irq[1], 1);

    // R4: out-of-range selects drive low
    wr(addr_of(2), NS);
    wr(addr_of(4), 16'hFFFF);
    @(negedge clk); src = '1; #1;
    chk(irq[2] === 1'b0, "R4 select at NUM_SRC", irq[2], 0);
    chk(irq[4] === 1'b0, "R4 select all ones", irq[4], 0);
    chk(irq[1] === 1'b1, "R3 contrast in range", irq[1], 1);
    rnd_on = 1;

    // R2: unaligned and past-end writes ignored
    wr(1, 9);
    wr(18, 9);
    wr(31, 9);
    for (int a = 0; a < 32; a++) rd_chk(a, model_read(a), "R2 ignored write");
    rd_chk(addr_of(1), NS - 1, "R2 neighbour unchanged");

    // R7: release
    rel(addr_of(6), 0, 0);
    rd_chk(addr_of(6), SAFE, "R7 release to safe");
    rel(addr_of(5), 0, 0);
    rd_chk(addr_of(5), 4, "R7 bypass release no effect");
    rel(addr_of(8), 1, 13);
    rd_chk(addr_of(8), SAFE, "R7 release beats write");

    // R9: full register width kept
    wr(addr_of(10), 16'hABCD);
    rd_chk(addr_of(10), 16'hABCD, "R9 full width");

    // R10: idle cycles keep contents
    repeat (5) @(negedge clk);
    rd_chk(addr_of(11), 14, "R10 idle hold");

    // R3 / R4: sweep every source number on one output
    for (int s = 0; s < NS + 2; s++) begin
      wr(addr_of(11), s);
      repeat (3) @(posedge clk);
    end
    rd_chk(addr_of(11), NS + 1, "R8 sweep final");

    repeat (4) @(posedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule